// File: doc/BRIEF.md
# Delayed-Write Holding Controller with Forwarding

This block sits in front of a single-port RAM whose stored words are masked with a keystream. A single keystream engine serves both reads and writes. Each write is therefore retired one cycle after it is accepted. It waits in a holding register and is committed in the first cycle that brings no read. A read that targets the address of the waiting write gets its answer from the holding register. Only the bits that the waiting write enables come from there; the other bits come from the RAM.

A request is accepted only while the key-valid input is high. Read data comes back one cycle after the read. The unscrambled address of the most recent read is kept on a 32-bit output for error reporting. A request marked with an integrity error is accepted but never reaches the RAM. For such a request the nonce given to the keystream engine is bit-reversed. The RAM and the keystream function are simple models inside the block. Stored data are masked with a keystream derived from the key, the nonce and the word address.

Top module: `dwr_hold_ctrl`

## Requirements
- R1: `gnt_o` equals `req_i` AND `key_valid_i`. A request that is not granted has no effect on memory contents, `rvalid_o` or `raddr_o`.
- R2: A granted write without integrity error (`write_i`=1, `intg_error_i`=0) is visible to every later granted read. Each read returns the word formed by all earlier accepted writes.
- R3: A pending write stays held, with its address unchanged, for as long as every cycle brings a granted read or a flagged request. It is committed in the first cycle that does not. No cycle both reads and writes the RAM.
- R4: A read to the address of the held write returns, for each bit, the held data where the held mask bit is 1 and the stored data where it is 0.
- R5: A burst of the form write, read, write, with further reads interleaved, leaves every written word correct. The scrambled copy of a held write survives the keystream engine being reused by the intervening read.
- R6: `wmask_i` works per bit. A write changes only the bits whose mask bit is 1.
- R7: A granted request with `intg_error_i`=1 causes no RAM access. A flagged write leaves memory unchanged. A flagged read still produces `rvalid_o` one cycle later, with `rdata_o` all zeros.
- R8: `rvalid_o` is high for exactly the one cycle after each granted read. `rdata_o` is zero whenever `rvalid_o` is low.
- R9: From the cycle after a granted read, `raddr_o` holds that read's unscrambled word address, zero-extended to 32 bits, until the next granted read.
- R10: The active-low reset clears the pending-write, read-valid and collision flags. After reset, `rvalid_o` and `rdata_o` are zero and no stale write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_valid_i | input | 1 | Key is usable; requests are granted only while high |
| key_i | input | Width | Keystream key |
| nonce_i | input | Width | Keystream nonce |
| req_i | input | 1 | Request strobe |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AddrWidth | Word address |
| wdata_i | input | Width | Write data |
| wmask_i | input | Width | Per-bit write enable |
| intg_error_i | input | 1 | Current request carries an integrity error |
| gnt_o | output | 1 | Request accepted |
| rdata_o | output | Width | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| raddr_o | output | 32 | Address of the last granted read |

## Verification
The bench drives writes followed at once by a read of the same address, with both full and partial masks. A design that skipped forwarding would return the old word there, and one that ignored the mask on the forwarded path would corrupt the unwritten bits. Runs of reads are placed behind a pending write, including reads to the pending address. These catch a controller that commits too early, which would collide with the read port, or that loses the held address. Write, read, write bursts check that the held scrambled word is not built from a keystream already taken over by a read; a mistake there shows up as a garbled word on a later read. Flagged requests and requests made with the key invalid must leave memory untouched. Flagged reads must still answer with zeros.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

  // Width of the error-reporting address output.
  localparam int unsigned RADDR_W = 32;

  // Operation presented to the RAM model in a cycle.
  typedef enum logic [1:0] {
    MEM_IDLE = 2'd0,
    MEM_RD   = 2'd1,
    MEM_WR   = 2'd2
  } mem_op_e;

endpackage

// File: rtl/dwr_keystream.sv
// Combinational keystream model: mixes key, nonce and word address.
module dwr_keystream #(
  parameter int unsigned Width     = 32,
  parameter int unsigned AddrWidth = 4,
  parameter int unsigned NumRounds = 2
) (
  input  logic [Width-1:0]     key_i,
  input  logic [Width-1:0]     nonce_i,
  input  logic [AddrWidth-1:0] addr_i,
  output logic [Width-1:0]     ks_o
);

  logic [Width-1:0] addr_rep;
  logic [Width-1:0] state;

  // Spread the address over the full word.
  for (genvar gi = 0; gi < Width; gi++) begin : g_rep
    assign addr_rep[gi] = addr_i[gi % AddrWidth];
  end

  always_comb begin
    state = key_i ^ nonce_i ^ addr_rep;
    for (int r = 0; r < NumRounds; r++) begin
      state = {state[Width-2:0], state[Width-1]}
            ^ ({state[Width-4:0], state[Width-1:Width-3]} & ~state)
            ^ key_i ^ Width'(r + 1);
    end
    ks_o = state;
  end

endmodule

// File: rtl/dwr_mem_model.sv
// Single-port RAM model with per-bit write enable and registered read data.
module dwr_mem_model
  import dwr_pkg::*;
#(
  parameter int unsigned Depth     = 16,
  parameter int unsigned Width     = 32,
  parameter int unsigned AddrWidth = $clog2(Depth)
) (
  input  logic                 clk_i,
  input  mem_op_e              op_i,
  input  logic [AddrWidth-1:0] addr_i,
  input  logic [Width-1:0]     wdata_i,
  input  logic [Width-1:0]     wmask_i,
  output logic [Width-1:0]     rdata_o
);

  logic [Width-1:0] mem_q [Depth];
  logic [Width-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (op_i == MEM_WR) begin
      mem_q[addr_i] <= (mem_q[addr_i] & ~wmask_i) | (wdata_i & wmask_i);
    end
    if (op_i == MEM_RD) begin
      rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/dwr_pending.sv
// Holding registers for one deferred write plus its scrambled copy.
module dwr_pending #(
  parameter int unsigned Width     = 32,
  parameter int unsigned AddrWidth = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,  // accepted write this cycle
  input  logic                 block_i,    // commit not allowed this cycle
  input  logic [AddrWidth-1:0] addr_i,
  input  logic [Width-1:0]     wdata_i,
  input  logic [Width-1:0]     wmask_i,
  input  logic [Width-1:0]     ks_q_i,     // keystream registered at last grant
  output logic                 pending_o,
  output logic                 commit_o,
  output logic [AddrWidth-1:0] waddr_o,
  output logic [Width-1:0]     wdata_o,
  output logic [Width-1:0]     wmask_o,
  output logic [Width-1:0]     scr_data_o
);

  logic                 pending_d, pending_q;
  logic                 fresh_q;
  logic [AddrWidth-1:0] waddr_q;
  logic [Width-1:0]     wdata_q, wmask_q, scr_held_q, scr_fresh;

  // Next state
  always_comb begin
    commit_o  = pending_q & ~block_i;
    pending_d = capture_i | (pending_q & block_i);
    scr_fresh = wdata_q ^ ks_q_i;
  end

  // Flags with reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      fresh_q   <= 1'b0;
    end else begin
      pending_q <= pending_d;
      fresh_q   <= capture_i;
    end
  end

  // Data registers, clock-enabled, no reset
  always_ff @(posedge clk_i) begin
    if (capture_i) begin
      waddr_q <= addr_i;
      wdata_q <= wdata_i;
      wmask_q <= wmask_i;
    end
    if (fresh_q) begin
      scr_held_q <= scr_fresh;
    end
  end

  // Keystream is still the write's own only in the cycle after capture.
  assign scr_data_o = fresh_q ? scr_fresh : scr_held_q;
  assign pending_o  = pending_q;
  assign waddr_o    = waddr_q;
  assign wdata_o    = wdata_q;
  assign wmask_o    = wmask_q;

  assert_hold_while_blocked_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && block_i |=> pending_q && $stable(waddr_q));

  assert_commit_when_free_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && !block_i && !capture_i |=> !pending_q);

  assert_capture_sets_pending_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> pending_q && !$stable(fresh_q) || (pending_q && fresh_q));

  assert_capture_not_blocked_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_i && block_i));

endmodule

// File: rtl/dwr_hold_ctrl.sv
module dwr_hold_ctrl
  import dwr_pkg::*;
#(
  parameter int unsigned Depth     = 16,
  parameter int unsigned Width     = 32,
  parameter int unsigned NumRounds = 2,
  parameter int unsigned AddrWidth = $clog2(Depth)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 key_valid_i,
  input  logic [Width-1:0]     key_i,
  input  logic [Width-1:0]     nonce_i,
  input  logic                 req_i,
  input  logic                 write_i,
  input  logic [AddrWidth-1:0] addr_i,
  input  logic [Width-1:0]     wdata_i,
  input  logic [Width-1:0]     wmask_i,
  input  logic                 intg_error_i,
  output logic                 gnt_o,
  output logic [Width-1:0]     rdata_o,
  output logic                 rvalid_o,
  output logic [RADDR_W-1:0]   raddr_o
);

  logic                 gnt, rd_any, rd_en, wr_cap, flagged, block;
  logic                 pending, commit, coll_d;
  logic [AddrWidth-1:0] waddr, addr_mux;
  logic [Width-1:0]     wdata_h, wmask_h, scr_wdata;
  logic [Width-1:0]     nonce_rev, nonce_eff, ks, mem_rdata, base, merged;
  mem_op_e              mem_op;

  logic                 rvalid_q, coll_q, rd_flag_q;
  logic [AddrWidth-1:0] raddr_q;
  logic [Width-1:0]     ks_q;

  // Request decode
  always_comb begin
    gnt     = req_i & key_valid_i;
    flagged = gnt & intg_error_i;
    rd_any  = gnt & ~write_i;
    rd_en   = rd_any & ~intg_error_i;
    wr_cap  = gnt & write_i & ~intg_error_i;
    block   = rd_en | flagged;
  end

  // Nonce is bit-reversed for a flagged request.
  for (genvar gi = 0; gi < Width; gi++) begin : g_nrev
    assign nonce_rev[gi] = nonce_i[Width-1-gi];
  end
  assign nonce_eff = intg_error_i ? nonce_rev : nonce_i;

  dwr_keystream #(
    .Width     (Width),
    .AddrWidth (AddrWidth),
    .NumRounds (NumRounds)
  ) u_ks (
    .key_i   (key_i),
    .nonce_i (nonce_eff),
    .addr_i  (addr_i),
    .ks_o    (ks)
  );

  dwr_pending #(
    .Width     (Width),
    .AddrWidth (AddrWidth)
  ) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (wr_cap),
    .block_i    (block),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wmask_i    (wmask_i),
    .ks_q_i     (ks_q),
    .pending_o  (pending),
    .commit_o   (commit),
    .waddr_o    (waddr),
    .wdata_o    (wdata_h),
    .wmask_o    (wmask_h),
    .scr_data_o (scr_wdata)
  );

  // RAM operation and address mux: pending address only without a read.
  always_comb begin
    if (rd_en)       mem_op = MEM_RD;
    else if (commit) mem_op = MEM_WR;
    else             mem_op = MEM_IDLE;
    addr_mux = rd_en ? addr_i : waddr;
    coll_d   = rd_en & pending & (addr_i == waddr);
  end

  dwr_mem_model #(
    .Depth     (Depth),
    .Width     (Width),
    .AddrWidth (AddrWidth)
  ) u_mem (
    .clk_i   (clk_i),
    .op_i    (mem_op),
    .addr_i  (addr_mux),
    .wdata_i (scr_wdata),
    .wmask_i (wmask_h),
    .rdata_o (mem_rdata)
  );

  // Flags with reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      coll_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_any;
      coll_q   <= coll_d;
    end
  end

  // Data registers, clock-enabled
  always_ff @(posedge clk_i) begin
    if (gnt) begin
      ks_q <= ks;
    end
    if (rd_any) begin
      raddr_q   <= addr_i;
      rd_flag_q <= intg_error_i;
    end
  end

  // Read path: remove keystream, then forward held bits on a collision.
  always_comb begin
    base    = mem_rdata ^ ks_q;
    merged  = coll_q ? ((wdata_h & wmask_h) | (base & ~wmask_h)) : base;
    rdata_o = (rvalid_q && !rd_flag_q) ? merged : '0;
  end

  assign gnt_o    = gnt;
  assign rvalid_o = rvalid_q;
  assign raddr_o  = RADDR_W'(raddr_q);

  assert_resp_needs_key_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(key_valid_i && req_i && !write_i));

  assert_read_gives_valid_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any |=> rvalid_o);

  assert_flag_silences_mem_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o && intg_error_i |-> mem_op == MEM_IDLE);

  assert_write_only_pending_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_op == MEM_WR |-> pending && !(req_i && key_valid_i && !write_i));

  assert_forward_has_resp_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_q |-> rvalid_o);

endmodule

// File: tb/dwr_hold_ctrl_bench.sv
module dwr_hold_ctrl_bench;
  localparam int W  = 32;
  localparam int D  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          key_valid, req, wr, flag;
  logic [W-1:0]  key, nonce, wdata, wmask;
  logic [AW-1:0] addr;
  logic          gnt, rvalid;
  logic [W-1:0]  rdata;
  logic [31:0]   raddr;

  always #5 clk = ~clk;

  dwr_hold_ctrl u_dwr_hold_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(key_valid), .key_i(key),
    .nonce_i(nonce), .req_i(req), .write_i(wr), .addr_i(addr),
    .wdata_i(wdata), .wmask_i(wmask), .intg_error_i(flag),
    .gnt_o(gnt), .rdata_o(rdata), .rvalid_o(rvalid), .raddr_o(raddr)
  );

  int errors = 0;
  int checks = 0;

  // Behavioural reference: architectural memory, last expected response.
  logic [W-1:0] ref_mem [D];
  logic         exp_rv = 1'b0;
  logic [W-1:0] exp_rd = '0;
  logic [31:0]  exp_ra = '0;
  logic         ra_known = 1'b0;
  string        exp_tag = "R10";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: check the previous response, drive a request, check grant.
  task automatic step(string tag, logic r, logic w, logic kv, logic f,
                      logic [AW-1:0] a, logic [W-1:0] d, logic [W-1:0] m);
    @(negedge clk);
    chk({exp_tag, " rvalid"}, 64'(rvalid), 64'(exp_rv));
    chk({exp_tag, " rdata"}, 64'(rdata), exp_rv ? 64'(exp_rd) : 64'd0);
    if (ra_known) chk("R9 raddr", 64'(raddr), 64'(exp_ra));
    req = r; wr = w; key_valid = kv; flag = f; addr = a; wdata = d; wmask = m;
    #1;
    chk({tag, " R1 gnt"}, 64'(gnt), 64'(r & kv));
    exp_rv  = 1'b0;
    exp_tag = tag;
    if (r && kv) begin
      if (!w) begin
        exp_rv   = 1'b1;
        exp_rd   = f ? '0 : ref_mem[a];
        exp_ra   = 32'(a);
        ra_known = 1'b1;
      end else if (!f) begin
        ref_mem[a] = (ref_mem[a] & ~m) | (d & m);
      end
    end
  endtask

  task automatic wr_op(string t, logic [AW-1:0] a, logic [W-1:0] d, logic [W-1:0] m);
    step(t, 1'b1, 1'b1, 1'b1, 1'b0, a, d, m);
  endtask
  task automatic rd_op(string t, logic [AW-1:0] a);
    step(t, 1'b1, 1'b0, 1'b1, 1'b0, a, '0, '0);
  endtask
  task automatic idle(string t);
    step(t, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; req = 1'b0; wr = 1'b0; flag = 1'b0;
    key = 32'h5A3C_96E1; nonce = 32'h0F1E_2D3C;
    addr = '0; wdata = '0; wmask = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset rvalid", 64'(rvalid), 64'd0);
    chk("R10 reset rdata", 64'(rdata), 64'd0);
    rst_n = 1'b1;
    idle("R10");
    idle("R10");

    // R2: fill every word, then read all back
    for (int i = 0; i < D; i++) wr_op("R2", AW'(i), 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0111), '1);
    for (int i = 0; i < D; i++) rd_op("R2", AW'(i));

    // R4: read right behind a write to the same address (full mask)
    wr_op("R4", 4'd3, 32'h1122_3344, '1);
    rd_op("R4", 4'd3);
    rd_op("R4", 4'd3);
    idle("R4");
    rd_op("R4", 4'd3);

    // R4 / R6: partial mask merged on the forwarding path
    wr_op("R4", 4'd5, 32'hFFFF_FFFF, 32'h00FF_0F0F);
    rd_op("R4", 4'd5);
    idle("R6");
    rd_op("R6", 4'd5);

    // R3: pending write held across a run of reads
    wr_op("R3", 4'd7, 32'hDEAD_BEEF, '1);
    rd_op("R3", 4'd8);
    rd_op("R3", 4'd9);
    rd_op("R3", 4'd7);
    rd_op("R3", 4'd7);
    idle("R3");
    rd_op("R3", 4'd7);

    // R5: write, read, write bursts
    wr_op("R5", 4'd1, 32'h0BAD_F00D, '1);
    rd_op("R5", 4'd2);
    wr_op("R5", 4'd4, 32'h1357_9BDF, '1);
    rd_op("R5", 4'd1);
    rd_op("R5", 4'd4);
    wr_op("R5", 4'd6, 32'h2468_ACE0, '1);
    rd_op("R5", 4'd6);
    wr_op("R5", 4'd10, 32'hCAFE_0001, '1);
    wr_op("R5", 4'd11, 32'hCAFE_0002, '1);
    wr_op("R5", 4'd10, 32'h0000_7700, 32'h0000_FF00);
    rd_op("R5", 4'd10);
    rd_op("R5", 4'd11);
    idle("R5");

    // R6: byte mask with no read behind it
    wr_op("R6", 4'd15, 32'h9900_0000, 32'hFF00_0000);
    idle("R6");
    idle("R6");
    rd_op("R6", 4'd15);

    // R1: key invalid, requests are refused and leave no trace
    step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 4'd12, 32'h7777_7777, '1);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, '0, '0);
    idle("R1");
    rd_op("R1", 4'd12);

    // R7: flagged write without and with a pending write, flagged read
    step("R7", 1'b1, 1'b1, 1'b1, 1'b1, 4'd13, 32'h5555_5555, '1);
    rd_op("R7", 4'd13);
    wr_op("R7", 4'd14, 32'h3C3C_3C3C, '1);
    step("R7", 1'b1, 1'b1, 1'b1, 1'b1, 4'd14, 32'hFFFF_0000, '1);
    rd_op("R7", 4'd14);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b1, 4'd14, '0, '0);
    rd_op("R7", 4'd14);

    idle("R8");
    idle("R8");
    summary();
    $finish;
  end

endmodule